// File: doc/BRIEF.md
# Rotating Hybrid Gate Pattern Generator for a Seven-Level Cascaded Bridge

This block turns three level-band comparator pulses into the twelve gate signals of a three-cell cascaded H-bridge inverter. The pulses come from comparing a rectified reference against three stacked carriers, so the scheme needs half as many carriers as a plain level-shifted modulator. A single strobe that marks each zero crossing of the reference drives the timing. From it the block derives a fundamental-rate polarity square wave and a half-rate role square wave. It also keeps a rotation index that moves the band pulses from cell to cell once per fundamental period.

Inside each bridge, the role signal picks which leg carries the fast band pulse while the other leg holds a fundamental-rate level. The polarity signal sets the sign of the cell voltage. Because the roles alternate and the bands rotate, every device spends time on both the slow and the fast pattern, which evens out switching loss. The gates follow the comparator inputs combinationally. The polarity, role and rotation state changes only on a strobe edge.

Top module: `rot_hybrid_gate`

## Requirements
- R1: After reset all twelve gates are low, and they stay low until the first cycle after the first strobe, whatever the comparator inputs do.
- R2: Every strobe toggles the polarity (1 = positive half). The first strobe sets it to 1 and arms the gates, and the new value applies from the cycle after the strobe.
- R3: The role bit starts at 0 and toggles on each strobe that takes the polarity from 1 to 0, which is every second strobe.
- R4: The rotation index starts at 0 and advances on the same strobes as the role bit, counting 0, 1, 2 and then wrapping to 0.
- R5: Cell k (k = 0, 1, 2) carries band (k + rotation) mod 3, where band 0 is `cmp_low`, band 1 is `cmp_mid` and band 2 is `cmp_high`.
- R6: Gate bit 4k+0 is the upper switch of leg 1 of cell k, bit 4k+1 its lower switch, and bits 4k+2 and 4k+3 are the upper and lower switches of leg 2. With role 0, leg 1 is high when the band equals the polarity and leg 2 is high when the polarity is 0. With role 1, leg 1 follows the polarity and leg 2 is high when the band differs from the polarity.
- R7: Once armed, the two switches of every leg are always complementary.
- R8: Once armed, each cell's voltage (leg 1 high minus leg 2 high) equals +band when the polarity is 1 and -band when it is 0.
- R9: Without a strobe, comparator activity leaves the rotation, role and polarity unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_low | input | 1 | Comparator pulse of the lowest carrier band |
| cmp_mid | input | 1 | Comparator pulse of the middle carrier band |
| cmp_high | input | 1 | Comparator pulse of the top carrier band |
| zero_cross | input | 1 | One-cycle strobe at each reference zero crossing |
| gate | output | 12 | Switch gates, four per cell, layout as in R6 |

## Verification
The gates are a combinational function of the comparator inputs and the registered state. A band change therefore shows up in the same cycle, and the state change from a strobe shows up in the cycle after it. The driver applies its inputs just after a rising edge and pushes the expected vector for that cycle. Any strobe it issued in the previous cycle has already been folded into its model by then. The monitor compares at the falling edge of the same cycle, so each check sees exactly one edge's worth of state change.

// File: rtl/rhg_pkg.sv
package rhg_pkg;
    localparam int CELLS          = 3;
    localparam int GATES_PER_CELL = 4;

    // Leg levels of one bridge: 1 means upper switch on.
    typedef struct packed {
        logic leg1;
        logic leg2;
    } legs_t;

    // Role 0: leg 1 modulates, leg 2 holds the fundamental level.
    // Role 1: leg 2 modulates, leg 1 holds the fundamental level.
    function automatic legs_t leg_levels(input logic pol, input logic role, input logic band);
        legs_t l;
        if (!role) begin
            l.leg1 = ~(pol ^ band);
            l.leg2 = ~pol;
        end else begin
            l.leg1 = pol;
            l.leg2 = pol ^ band;
        end
        return l;
    endfunction
endpackage

// File: rtl/rhg_phase_tracker.sv
module rhg_phase_tracker #(
    parameter int N_CELLS = 3,
    localparam int RW = (N_CELLS > 1) ? $clog2(N_CELLS) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          strobe,
    output logic          pol,
    output logic          role,
    output logic          armed,
    output logic [RW-1:0] rot
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pol   <= 1'b0;
            role  <= 1'b0;
            armed <= 1'b0;
            rot   <= '0;
        end else if (strobe) begin
            armed <= 1'b1;
            pol   <= ~pol;
            if (pol) begin
                role <= ~role;
                rot  <= (rot == RW'(N_CELLS - 1)) ? '0 : rot + 1'b1;
            end
        end
    end
endmodule

// File: rtl/rhg_band_rotator.sv
module rhg_band_rotator #(
    parameter int N_CELLS = 3,
    localparam int RW = (N_CELLS > 1) ? $clog2(N_CELLS) : 1
) (
    input  logic [N_CELLS-1:0] bands,
    input  logic [RW-1:0]      rot,
    output logic [N_CELLS-1:0] cell_band
);
    for (genvar k = 0; k < N_CELLS; k++) begin : g_mux
        logic [RW:0] sum;
        logic [RW:0] idx;
        assign sum = (RW+1)'(k) + {1'b0, rot};
        assign idx = (sum >= (RW+1)'(N_CELLS)) ? sum - (RW+1)'(N_CELLS) : sum;
        assign cell_band[k] = bands[idx[RW-1:0]];
    end
endmodule

// File: rtl/rhg_gate_logic.sv
module rhg_gate_logic #(
    parameter int N_CELLS = 3,
    localparam int NG = N_CELLS * rhg_pkg::GATES_PER_CELL
) (
    input  logic               pol,
    input  logic               role,
    input  logic               armed,
    input  logic [N_CELLS-1:0] cell_band,
    output logic [NG-1:0]      gates
);
    import rhg_pkg::*;
    for (genvar k = 0; k < N_CELLS; k++) begin : g_cell
        legs_t l;
        assign l = leg_levels(pol, role, cell_band[k]);
        assign gates[4*k+0] = armed &  l.leg1;
        assign gates[4*k+1] = armed & ~l.leg1;
        assign gates[4*k+2] = armed &  l.leg2;
        assign gates[4*k+3] = armed & ~l.leg2;
    end
endmodule

// File: rtl/rot_hybrid_gate.sv
module rot_hybrid_gate #(
    parameter int N_CELLS = rhg_pkg::CELLS,
    localparam int RW = (N_CELLS > 1) ? $clog2(N_CELLS) : 1,
    localparam int NG = N_CELLS * rhg_pkg::GATES_PER_CELL
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmp_low,
    input  logic          cmp_mid,
    input  logic          cmp_high,
    input  logic          zero_cross,
    output logic [NG-1:0] gate
);
    logic          pol;
    logic          role;
    logic          armed;
    logic [RW-1:0] rot;
    logic [2:0]    bands;
    logic [2:0]    cell_band;

    assign bands = {cmp_high, cmp_mid, cmp_low};

    rhg_phase_tracker #(.N_CELLS(N_CELLS)) u_phase (
        .clk(clk), .rst(rst), .strobe(zero_cross),
        .pol(pol), .role(role), .armed(armed), .rot(rot)
    );

    rhg_band_rotator #(.N_CELLS(N_CELLS)) u_rot (
        .bands(bands), .rot(rot), .cell_band(cell_band)
    );

    rhg_gate_logic #(.N_CELLS(N_CELLS)) u_gates (
        .pol(pol), .role(role), .armed(armed),
        .cell_band(cell_band), .gates(gate)
    );
endmodule

// File: rtl/rhg_checker.sv
module rhg_checker #(
    parameter int N_CELLS = 3,
    localparam int RW = (N_CELLS > 1) ? $clog2(N_CELLS) : 1,
    localparam int NG = N_CELLS * 4
) (
    input logic          clk,
    input logic          rst,
    input logic          zero_cross,
    input logic          pol,
    input logic          role,
    input logic          armed,
    input logic [RW-1:0] rot,
    input logic [NG-1:0] gate
);
    logic legs_ok;
    always_comb begin
        legs_ok = 1'b1;
        for (int i = 0; i < 2 * N_CELLS; i++)
            if (gate[2*i] == gate[2*i+1]) legs_ok = 1'b0;
    end

    p_idle_low_r1: assert property (@(posedge clk) disable iff (rst)
        !armed |-> (gate == '0));
    p_pol_toggle_r2: assert property (@(posedge clk) disable iff (rst)
        zero_cross |=> (pol != $past(pol)));
    p_role_on_fall_r3: assert property (@(posedge clk) disable iff (rst)
        (zero_cross && pol) |=> (role != $past(role)));
    p_rot_range_r4: assert property (@(posedge clk) disable iff (rst)
        rot < RW'(N_CELLS));
    p_legs_comp_r7: assert property (@(posedge clk) disable iff (rst)
        armed |-> legs_ok);
    p_hold_no_strobe_r9: assert property (@(posedge clk) disable iff (rst)
        !zero_cross |=> ($stable(rot) && $stable(role) && $stable(pol)));
endmodule

bind rot_hybrid_gate rhg_checker #(.N_CELLS(N_CELLS)) u_chk (
    .clk(clk), .rst(rst), .zero_cross(zero_cross), .pol(pol),
    .role(role), .armed(armed), .rot(rot), .gate(gate)
);

// File: tb/rot_hybrid_gate_test.sv
module rot_hybrid_gate_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        c_lo = 1'b0, c_mid = 1'b0, c_hi = 1'b0, zc = 1'b0;
    logic [11:0] gate;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [11:0] g;
        string       tag;
        logic        armed;
        logic        a;
        logic [2:0]  p;
    } item_t;
    item_t q[$];

    // reference model state
    logic m_a = 0, m_b = 0, m_armed = 0, pend = 0;
    int   m_rot = 0;

    always #5 clk = ~clk;

    rot_hybrid_gate uut (
        .clk(clk), .rst(rst), .cmp_low(c_lo), .cmp_mid(c_mid),
        .cmp_high(c_hi), .zero_cross(zc), .gate(gate)
    );

    task automatic step(input logic [2:0] bands, input logic strobe, input string tag);
        item_t it;
        logic [2:0] bb;
        @(posedge clk); #1;
        if (pend) begin
            m_armed = 1;
            if (m_a) begin
                m_b = ~m_b;
                m_rot = (m_rot + 1) % 3;
            end
            m_a = ~m_a;
        end
        pend = strobe;
        {c_hi, c_mid, c_lo} = bands;
        zc = strobe;
        bb = bands;
        it.g = '0;
        for (int k = 0; k < 3; k++) begin
            logic p, l1, l2;
            p = bb[(k + m_rot) % 3];
            it.p[k] = p;
            if (!m_b) begin l1 = m_a ? p : ~p; l2 = ~m_a; end
            else      begin l1 = m_a;          l2 = m_a ? ~p : p; end
            if (m_armed) begin
                it.g[4*k+0] = l1; it.g[4*k+1] = ~l1;
                it.g[4*k+2] = l2; it.g[4*k+3] = ~l2;
            end
        end
        it.tag = tag; it.armed = m_armed; it.a = m_a;
        q.push_back(it);
    endtask

    // monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                checks++;
                if (gate !== it.g) begin
                    errors++;
                    $display("FAIL %s gate act=%b exp=%b", it.tag, gate, it.g);
                end
                for (int k = 0; k < 3; k++) begin
                    int v, ev;
                    v  = int'(gate[4*k]) - int'(gate[4*k+2]);
                    ev = !it.armed ? 0 : (it.a ? int'(it.p[k]) : -int'(it.p[k]));
                    checks++;
                    if (v != ev) begin
                        errors++;
                        $display("FAIL R8 cell%0d voltage act=%0d exp=%0d", k, v, ev);
                    end
                    if (it.armed) begin
                        checks++;
                        if (gate[4*k] == gate[4*k+1] || gate[4*k+2] == gate[4*k+3]) begin
                            errors++;
                            $display("FAIL R7 cell%0d legs act=%b exp=complementary", k, gate[4*k+:4]);
                        end
                    end
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1: idle with comparator activity, no strobe
        for (int i = 0; i < 8; i++) step(3'(i), 1'b0, "R1");
        for (int per = 0; per < 8; per++) begin
            for (int half = 0; half < 2; half++) begin
                step(3'b010, 1'b1, "R2");
                for (int j = 0; j < 3; j++)
                    step(3'b001 << j, 1'b0, (per == 3) ? "R4" : "R5");
                for (int j = 0; j < 4; j++)
                    step(3'((per * 5 + half * 3 + j * 7) % 8), 1'b0,
                         (half == 1) ? "R3" : "R6");
                step(3'b111, 1'b0, "R9");
                step(3'b000, 1'b0, "R9");
            end
        end
        step(3'b000, 1'b0, "R9");
        @(negedge clk); @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule